// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation tables through a simple memory read/write port. A base register, loaded through its own write port, holds the physical start of the top-level directory for the running process. For each accepted request the block reads one directory entry and, when that entry is present, one leaf entry. It then either returns a physical address or one of three fault codes. Only one walk is in flight at a time.

The virtual address is split into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit byte offset. Every table holds 1024 entries of 4 bytes, so an entry sits at the table base plus four times its index. Each entry uses this layout: bit 0 present, bit 1 writable, bit 2 dirty, bits 4:3 allocation state (00 unused, 01 reserved, 10 committed, 11 treated as unused), and bits 31:12 frame number. In a directory entry only the present bit and the frame number have any meaning. A write that reaches a clean, writable, usable page first stores the leaf entry back to memory with its dirty bit set, and only then responds.

Fault codes on `rsp_fault`: 0 none, 1 not present, 2 write to a read-only page, 3 access to an unused page.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The first memory access of a walk is a read at base + 4 × vaddr[31:22]. The base used is the value the base register held when the request was accepted. A base write during a walk affects only later walks.
- R3: When the directory entry's bit 0 is clear, the walk performs exactly one memory read and responds with fault code 1. The state, writable and dirty bits of a directory entry have no effect.
- R4: The second memory access is a read at {directory entry bits 31:12, 12'h000} + 4 × vaddr[21:12].
- R5: When the leaf state bits 4:3 are 00 or 11, the response carries fault code 3, whatever the present, writable and dirty bits and the access type.
- R6: When the leaf state is 01 or 10 and leaf bit 0 is clear, the response carries fault code 1. Every faulting response drives `rsp_paddr` to 0.
- R7: A write to a usable, present leaf with bit 1 clear responds with fault code 2 and issues no memory write. A read of the same page succeeds.
- R8: A successful walk responds with fault code 0 and `rsp_paddr` = {leaf bits 31:12, vaddr[11:0]}.
- R9: A successful write whose leaf has bit 2 clear issues, before responding, exactly one memory write to the leaf address with data = leaf entry with bit 2 set. Reads, and writes to pages that are already dirty, issue no memory write.
- R10: `req_ready` is low from the cycle after a request is accepted until the cycle after the response handshake. No second request is taken in between.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response and its fields hold steady.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (address, write flag, data) holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Load the directory base register |
| base_wr_data | input | 32 | New directory base (physical byte address) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request can be accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 write protect, 3 unused page |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_we | output | 1 | 1 for the dirty write-back, 0 for a read |
| mem_req_wdata | output | 32 | Entry data for the write-back |
| mem_rsp_valid | input | 1 | Read data valid (one cycle per read) |
| mem_rsp_data | input | 32 | Read entry data |

## Verification
The hardest case to reach from the ports is a base register write that lands while a walk is in flight. The bench slows the memory model down with a read latency of several cycles, writes a new base from a parallel thread, and checks that the first read address still comes from the old base while the next walk uses the new one. The dirty write-back under a stalling memory is also hard to reach. Random back-pressure on `mem_req_ready` holds the write-back pending for several cycles, and a repeat write to the same page must then produce no second write.

// File: rtl/xw_pkg.sv
// Package: shared encodings of the two-level translation walker.
// Assumes a 32-bit entry whose low bits carry the control fields below.
package xw_pkg;

    // Entry field positions
    localparam int unsigned F_PRESENT  = 0;
    localparam int unsigned F_WRITABLE = 1;
    localparam int unsigned F_DIRTY    = 2;
    localparam int unsigned F_STATE_LO = 3;
    localparam int unsigned F_STATE_W  = 2;
    localparam int unsigned F_CTRL_TOP = F_STATE_LO + F_STATE_W - 1;

    // Allocation state of a page
    typedef enum logic [1:0] {
        PS_UNUSED    = 2'b00,
        PS_RESERVED  = 2'b01,
        PS_COMMITTED = 2'b10,
        PS_ILLEGAL   = 2'b11
    } page_state_e;

    // Response fault code
    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WPROT  = 2'd2,
        FLT_UNUSED = 2'd3
    } fault_e;

    // Walk sequencer states
    typedef enum logic [2:0] {
        WS_IDLE,
        WS_DIR_REQ,
        WS_DIR_WAIT,
        WS_LEAF_REQ,
        WS_LEAF_WAIT,
        WS_MARK,
        WS_RESP
    } walk_st_e;

endpackage

// File: rtl/xw_entry_decode.sv
// Module: splits a raw table entry into its control fields and frame number.
// Assumes the frame number occupies the top FRAME_W bits of the entry.
module xw_entry_decode
    import xw_pkg::*;
#(
    parameter int unsigned ENT_W   = 32,
    parameter int unsigned FRAME_W = 20
) (
    input  logic [ENT_W-1:0]   ent,
    output logic               present,
    output logic               writable,
    output logic               dirty,
    output page_state_e        state,
    output logic [FRAME_W-1:0] frame
);
    localparam int unsigned SPARE_LO = F_CTRL_TOP + 1;
    localparam int unsigned SPARE_HI = ENT_W - FRAME_W - 1;

    logic spare_unused;

    // Field extraction
    always_comb begin
        present  = ent[F_PRESENT];
        writable = ent[F_WRITABLE];
        dirty    = ent[F_DIRTY];
        state    = page_state_e'(ent[F_STATE_LO +: F_STATE_W]);
        frame    = ent[ENT_W-1 -: FRAME_W];
    end

    // Bits between the control fields and the frame carry no meaning here
    assign spare_unused = ^ent[SPARE_HI:SPARE_LO];

endmodule

// File: rtl/xw_leaf_check.sv
// Module: classifies a leaf entry against the access type.
// Priority: unused state, then absence, then write protection.
// Also flags a write that must set the dirty bit first.
module xw_leaf_check
    import xw_pkg::*;
(
    input  logic        present,
    input  logic        writable,
    input  logic        dirty,
    input  page_state_e state,
    input  logic        is_write,
    output fault_e      fault,
    output logic        need_mark
);
    // Fault classification in priority order
    always_comb begin
        if (state == PS_UNUSED || state == PS_ILLEGAL) begin
            fault = FLT_UNUSED;
        end else if (!present) begin
            fault = FLT_ABSENT;
        end else if (is_write && !writable) begin
            fault = FLT_WPROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    // Dirty write-back needed only for a successful write to a clean page
    assign need_mark = (fault == FLT_NONE) && is_write && !dirty;

endmodule

// File: rtl/xw_addr_gen.sv
// Module: forms the directory entry address, leaf entry address and final
// physical address from captured walk state. Purely combinational.
// Assumes VA_W = 2*IDX_W + OFF_W and PA_W = FRAME_W + OFF_W.
module xw_addr_gen #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned PA_W     = 32,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned OFF_W    = 12,
    parameter int unsigned ESZ_LOG2 = 2
) (
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PA_W-1:0]       dir_base,
    input  logic [PA_W-OFF_W-1:0] tbl_frame,
    input  logic [PA_W-OFF_W-1:0] leaf_frame,
    output logic [PA_W-1:0]       dir_addr,
    output logic [PA_W-1:0]       leaf_addr,
    output logic [PA_W-1:0]       final_addr
);
    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [PA_W-1:0]  tbl_base;

    // Index fields of the virtual address
    assign dir_idx  = vaddr[VA_W-1 -: IDX_W];
    assign tbl_idx  = vaddr[OFF_W +: IDX_W];
    assign tbl_base = {tbl_frame, {OFF_W{1'b0}}};

    // Entry addresses: table base plus scaled index
    assign dir_addr  = dir_base + (PA_W'(dir_idx) << ESZ_LOG2);
    assign leaf_addr = tbl_base + (PA_W'(tbl_idx) << ESZ_LOG2);

    // Physical address: frame number joined to the byte offset
    assign final_addr = {leaf_frame, vaddr[OFF_W-1:0]};

endmodule

// File: rtl/xw_walk_seq.sv
// Module: sequences one walk at a time: directory read, leaf read,
// optional dirty write-back, then a held response.
// Assumes one mem_rsp_valid pulse per accepted read, never for a write.
module xw_walk_seq
    import xw_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned ENT_W   = 32,
    parameter int unsigned FRAME_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PA_W-1:0]    base_in,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    output logic               mem_req_we,
    output logic [ENT_W-1:0]   mem_req_wdata,
    input  logic               mem_rsp_valid,
    input  logic [ENT_W-1:0]   mem_rsp_data,
    input  logic               ent_present,
    input  logic [FRAME_W-1:0] ent_frame,
    input  fault_e             leaf_fault,
    input  logic               leaf_mark,
    input  logic [PA_W-1:0]    dir_addr,
    input  logic [PA_W-1:0]    leaf_addr,
    input  logic [PA_W-1:0]    final_addr,
    output logic [VA_W-1:0]    va_q,
    output logic               wr_q,
    output logic [PA_W-1:0]    base_q,
    output logic [FRAME_W-1:0] tbl_frame_q
);
    localparam logic [ENT_W-1:0] DIRTY_MASK = ENT_W'(1) << F_DIRTY;

    walk_st_e          st;
    logic [ENT_W-1:0]  leaf_q;
    fault_e            fault_q;
    logic [PA_W-1:0]   paddr_q;

    // Walk state machine and captured walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= WS_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            base_q      <= '0;
            tbl_frame_q <= '0;
            leaf_q      <= '0;
            fault_q     <= FLT_NONE;
            paddr_q     <= '0;
        end else begin
            case (st)
                WS_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        wr_q   <= req_write;
                        base_q <= base_in;
                        st     <= WS_DIR_REQ;
                    end
                end
                WS_DIR_REQ: begin
                    if (mem_req_ready) st <= WS_DIR_WAIT;
                end
                WS_DIR_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (ent_present) begin
                            tbl_frame_q <= ent_frame;
                            st          <= WS_LEAF_REQ;
                        end else begin
                            fault_q <= FLT_ABSENT;
                            paddr_q <= '0;
                            st      <= WS_RESP;
                        end
                    end
                end
                WS_LEAF_REQ: begin
                    if (mem_req_ready) st <= WS_LEAF_WAIT;
                end
                WS_LEAF_WAIT: begin
                    if (mem_rsp_valid) begin
                        leaf_q  <= mem_rsp_data;
                        fault_q <= leaf_fault;
                        paddr_q <= (leaf_fault == FLT_NONE) ? final_addr : '0;
                        st      <= leaf_mark ? WS_MARK : WS_RESP;
                    end
                end
                WS_MARK: begin
                    if (mem_req_ready) st <= WS_RESP;
                end
                WS_RESP: begin
                    if (rsp_ready) st <= WS_IDLE;
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    // Handshake and memory request outputs decoded from the state
    always_comb begin
        req_ready     = (st == WS_IDLE);
        rsp_valid     = (st == WS_RESP);
        rsp_paddr     = paddr_q;
        rsp_fault     = fault_q;
        mem_req_valid = (st == WS_DIR_REQ) || (st == WS_LEAF_REQ) || (st == WS_MARK);
        mem_req_we    = (st == WS_MARK);
        mem_req_addr  = (st == WS_DIR_REQ) ? dir_addr : leaf_addr;
        mem_req_wdata = (st == WS_MARK) ? (leaf_q | DIRTY_MASK) : '0;
    end

endmodule

// File: rtl/xlat_walker_chk.sv
// Module: protocol checker for the translation walker, bound to the top.
module xlat_walker_chk #(
    parameter int unsigned PA_W  = 32,
    parameter int unsigned ENT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_req_we,
    input logic [ENT_W-1:0] mem_req_wdata
);
    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    no_ready_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R1
    no_mem_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
             && $stable(mem_req_wdata)));

    // R9
    mark_sets_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> mem_req_wdata[2]);

    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

endmodule

// File: rtl/xlat_walker.sv
// Module: two-level address translation walker (top).
// Holds the directory base register and connects the sequencer, entry
// decoder, leaf classifier and address generator. One walk at a time.
module xlat_walker
    import xw_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned PA_W  = 32,
    parameter int unsigned IDX_W = 10,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned ENT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_en,
    input  logic [PA_W-1:0]  base_wr_data,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic             mem_req_we,
    output logic [ENT_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data
);
    localparam int unsigned FRAME_W  = PA_W - OFF_W;
    localparam int unsigned ESZ_LOG2 = $clog2(ENT_W / 8);

    logic [PA_W-1:0]    base_reg;
    logic               ent_present;
    logic               ent_writable;
    logic               ent_dirty;
    page_state_e        ent_state;
    logic [FRAME_W-1:0] ent_frame;
    fault_e             leaf_fault;
    logic               leaf_mark;
    logic [PA_W-1:0]    dir_addr;
    logic [PA_W-1:0]    leaf_addr;
    logic [PA_W-1:0]    final_addr;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic [PA_W-1:0]    base_q;
    logic [FRAME_W-1:0] tbl_frame_q;

    // Directory base register, loaded by software at any time
    always_ff @(posedge clk) begin
        if (!rst_n) base_reg <= '0;
        else if (base_wr_en) base_reg <= base_wr_data;
    end

    xw_entry_decode #(
        .ENT_W   (ENT_W),
        .FRAME_W (FRAME_W)
    ) u_dec (
        .ent      (mem_rsp_data),
        .present  (ent_present),
        .writable (ent_writable),
        .dirty    (ent_dirty),
        .state    (ent_state),
        .frame    (ent_frame)
    );

    xw_leaf_check u_cls (
        .present   (ent_present),
        .writable  (ent_writable),
        .dirty     (ent_dirty),
        .state     (ent_state),
        .is_write  (wr_q),
        .fault     (leaf_fault),
        .need_mark (leaf_mark)
    );

    xw_addr_gen #(
        .VA_W     (VA_W),
        .PA_W     (PA_W),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .ESZ_LOG2 (ESZ_LOG2)
    ) u_agen (
        .vaddr      (va_q),
        .dir_base   (base_q),
        .tbl_frame  (tbl_frame_q),
        .leaf_frame (ent_frame),
        .dir_addr   (dir_addr),
        .leaf_addr  (leaf_addr),
        .final_addr (final_addr)
    );

    xw_walk_seq #(
        .VA_W    (VA_W),
        .PA_W    (PA_W),
        .ENT_W   (ENT_W),
        .FRAME_W (FRAME_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .base_in       (base_reg),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_write     (req_write),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_we    (mem_req_we),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .ent_present   (ent_present),
        .ent_frame     (ent_frame),
        .leaf_fault    (leaf_fault),
        .leaf_mark     (leaf_mark),
        .dir_addr      (dir_addr),
        .leaf_addr     (leaf_addr),
        .final_addr    (final_addr),
        .va_q          (va_q),
        .wr_q          (wr_q),
        .base_q        (base_q),
        .tbl_frame_q   (tbl_frame_q)
    );

endmodule

bind xlat_walker xlat_walker_chk #(
    .PA_W  (PA_W),
    .ENT_W (ENT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_we    (mem_req_we),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
// Bench: behavioural memory and walk model, compared against the walker.
module sim_xlat_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_req_we;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #4 clk = ~clk;

    xlat_walker u0 (
        .clk (clk), .rst_n (rst_n),
        .base_wr_en (base_wr_en), .base_wr_data (base_wr_data),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .req_write (req_write),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr), .mem_req_we (mem_req_we),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [bit [31:0]];
    logic [31:0] base_model = '0;
    int          lat = 0;
    bit          stall = 1'b0;
    bit          started = 1'b0;
    bit          busy_m = 1'b0;
    bit          pend = 1'b0;
    int          pend_cnt = 0;
    logic [31:0] pend_data = '0;
    bit          held = 1'b0;
    logic [31:0] held_a, held_d;
    logic        held_we;

    logic [31:0] exp_a[$], obs_a[$], exp_d[$], obs_d[$];
    bit          exp_we[$], obs_we[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // entry: frame, state, dirty, writable, present
    function automatic logic [31:0] mk(input logic [19:0] fr, input logic [1:0] st,
                                       input bit d, input bit w, input bit p);
        return {fr, 7'h00, st, d, w, p};
    endfunction

    function automatic logic [31:0] va(input int di, input int ti, input int off);
        return {di[9:0], ti[9:0], off[11:0]};
    endfunction

    // Expected walk outcome and memory traffic from the bench memory
    task automatic model(input logic [31:0] v, input bit wr, input logic [31:0] b,
                         output logic [1:0] f, output logic [31:0] pa, output string tag);
        logic [31:0] da, de, ta, pte;
        exp_a.delete(); exp_we.delete(); exp_d.delete();
        da = b + {20'h0, v[31:22], 2'b00};
        de = rd(da);
        exp_a.push_back(da); exp_we.push_back(1'b0); exp_d.push_back(32'h0);
        pa = 32'h0;
        if (!de[0]) begin
            f = 2'd1; tag = "R3";
            return;
        end
        ta = {de[31:12], 12'h000} + {20'h0, v[21:12], 2'b00};
        pte = rd(ta);
        exp_a.push_back(ta); exp_we.push_back(1'b0); exp_d.push_back(32'h0);
        if (pte[4:3] == 2'b00 || pte[4:3] == 2'b11) begin
            f = 2'd3; tag = "R5";
        end else if (!pte[0]) begin
            f = 2'd1; tag = "R6";
        end else if (wr && !pte[1]) begin
            f = 2'd2; tag = "R7";
        end else begin
            f = 2'd0; tag = "R8";
            pa = {pte[31:12], v[11:0]};
            if (wr && !pte[2]) begin
                exp_a.push_back(ta); exp_we.push_back(1'b1);
                exp_d.push_back(pte | 32'h4);
            end
        end
    endtask

    // Memory driver: read data after lat cycles, ready per stall mode
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hDEAD_BEEF;
            if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pend_data;
                    pend = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            mem_req_ready = stall ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    // Monitor: sampled 1 ns after the falling edge, ahead of the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && started) begin
                // R10: ready low exactly while a walk is outstanding
                chk(req_ready == !busy_m, "R10", "req_ready vs busy", 32'(req_ready), 32'(!busy_m));
                if (req_valid && req_ready) busy_m = 1'b1;
                if (rsp_valid && rsp_ready) busy_m = 1'b0;
                if (held) begin
                    chk(mem_req_valid && mem_req_addr == held_a && mem_req_we == held_we
                        && mem_req_wdata == held_d, "R12", "stalled mem request held",
                        mem_req_addr, held_a);
                    held = 1'b0;
                end
                if (mem_req_valid && !mem_req_ready) begin
                    held = 1'b1; held_a = mem_req_addr; held_we = mem_req_we; held_d = mem_req_wdata;
                end
                if (mem_req_valid && mem_req_ready) begin
                    obs_a.push_back(mem_req_addr);
                    obs_we.push_back(mem_req_we);
                    obs_d.push_back(mem_req_we ? mem_req_wdata : 32'h0);
                    if (mem_req_we) begin
                        mem[mem_req_addr] = mem_req_wdata;
                    end else begin
                        pend = 1'b1; pend_cnt = lat; pend_data = rd(mem_req_addr);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R10 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = b;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    // One complete walk with checks on the response and memory traffic
    task automatic walk(input logic [31:0] v, input bit wr, input int hold);
        logic [1:0]  f;
        logic [31:0] pa;
        string       tag;
        model(v, wr, base_model, f, pa, tag);
        obs_a.delete(); obs_we.delete(); obs_d.delete();
        @(negedge clk);
        req_vaddr = v; req_write = wr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(rsp_fault == f, tag, "fault code", 32'(rsp_fault), 32'(f));
        chk(rsp_paddr == pa, tag, "physical address", rsp_paddr, pa);
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            // R11: response held while not consumed
            chk(rsp_valid && rsp_fault == f && rsp_paddr == pa, "R11", "held response",
                rsp_paddr, pa);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(obs_a.size() == exp_a.size(), "R3/R7/R9", "memory op count",
            32'(obs_a.size()), 32'(exp_a.size()));
        for (int i = 0; i < obs_a.size() && i < exp_a.size(); i++) begin
            string t;
            t = (i == 0) ? "R2" : (i == 1) ? "R4" : "R9";
            chk(obs_a[i] == exp_a[i], t, "memory address", obs_a[i], exp_a[i]);
            chk(obs_we[i] == exp_we[i], t, "memory write flag", 32'(obs_we[i]), 32'(exp_we[i]));
            chk(obs_d[i] == exp_d[i], t, "memory write data", obs_d[i], exp_d[i]);
        end
    endtask

    localparam logic [31:0] B0 = 32'h0010_0000;
    localparam logic [31:0] B1 = 32'h0030_0000;

    logic [31:0] pool [12];

    initial begin
        // Table setup
        mem[B0 + 4*1] = mk(20'h00200, 2'b10, 1, 1, 1);
        mem[B0 + 4*2] = 32'hFFFF_F01E;                    // absent dir, junk bits
        mem[B0 + 4*3] = mk(20'h00201, 2'b00, 0, 0, 1);    // state bits ignored in dir
        mem[32'h0020_0000 + 4*0] = mk(20'h12345, 2'b10, 0, 1, 1);
        mem[32'h0020_0000 + 4*1] = mk(20'h22222, 2'b10, 0, 0, 1);
        mem[32'h0020_0000 + 4*2] = mk(20'h33333, 2'b00, 1, 1, 1);
        mem[32'h0020_0000 + 4*3] = mk(20'h77777, 2'b11, 0, 1, 1);
        mem[32'h0020_0000 + 4*4] = mk(20'hABCDE, 2'b01, 0, 1, 0);
        mem[32'h0020_0000 + 4*5] = mk(20'h88888, 2'b01, 1, 1, 1);
        mem[32'h0020_0000 + 4*6] = mk(20'h99999, 2'b10, 0, 1, 0);
        mem[32'h0020_0000 + 4*7] = mk(20'h11111, 2'b00, 0, 0, 0);
        mem[32'h0020_0000 + 4*8] = mk(20'h44444, 2'b10, 1, 1, 1);
        mem[32'h0020_1000 + 4*0]    = mk(20'h55555, 2'b10, 0, 1, 1);
        mem[32'h0020_1000 + 4*1023] = mk(20'hFEDCB, 2'b10, 0, 0, 1);
        mem[B1 + 4*1] = mk(20'h00202, 2'b10, 0, 0, 1);
        mem[32'h0020_2000 + 4*0] = mk(20'h66666, 2'b10, 0, 1, 1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);
        started = 1'b1;

        set_base(B0); base_model = B0;

        walk(va(1, 0, 12'h0AB), 0, 0);   // R8 clean read: no write-back
        walk(va(1, 0, 12'hFFC), 1, 0);   // R9 write-back of clean page
        walk(va(1, 0, 12'h004), 1, 0);   // R9 now dirty: no second write
        walk(va(1, 1, 12'h010), 1, 0);   // R7 read-only write
        walk(va(1, 1, 12'h010), 0, 0);   // R7 read of read-only page
        walk(va(2, 5, 12'h123), 0, 0);   // R3 absent directory
        walk(va(2, 5, 12'h123), 1, 0);   // R3 absent directory on write
        walk(va(1, 2, 12'h000), 0, 0);   // R5 state 00 present
        walk(va(1, 3, 12'h000), 1, 0);   // R5 state 11
        walk(va(1, 7, 12'h000), 0, 0);   // R5 state 00 absent
        walk(va(1, 4, 12'h321), 0, 0);   // R6 reserved absent
        walk(va(1, 6, 12'h321), 1, 0);   // R6 committed absent
        walk(va(1, 5, 12'h777), 1, 0);   // R8 reserved present dirty
        walk(va(1, 8, 12'h001), 1, 0);   // R9 already dirty
        walk(va(3, 0, 12'h000), 1, 0);   // R4 dir state ignored, write-back
        walk(va(3, 1023, 12'hFFF), 0, 0); // R4 last table index
        walk(va(1023, 0, 12'h000), 0, 0); // R3 untouched entry reads as zero
        walk(va(1, 0, 12'h55A), 0, 4);   // R11 response held
        walk(va(1, 1, 12'h000), 1, 3);   // R11 held fault response

        // R2: base rewritten during a slow walk
        lat = 6;
        fork
            walk(va(1, 0, 12'h100), 0, 0);
            begin
                repeat (3) @(negedge clk);
                set_base(B1);
            end
        join
        base_model = B1;
        lat = 0;
        walk(va(1, 0, 12'h200), 1, 0);   // R2 new base, R9 write-back in new table
        set_base(B0); base_model = B0;

        // R12: random back-pressure and latency over a pool of addresses
        pool[0] = va(1, 0, 0);  pool[1] = va(1, 1, 0);  pool[2] = va(1, 2, 0);
        pool[3] = va(1, 3, 0);  pool[4] = va(1, 4, 0);  pool[5] = va(1, 5, 0);
        pool[6] = va(1, 6, 0);  pool[7] = va(1, 8, 0);  pool[8] = va(2, 0, 0);
        pool[9] = va(3, 0, 0);  pool[10] = va(3, 1023, 0); pool[11] = va(9, 9, 0);
        mem[32'h0020_1000 + 4*2] = mk(20'h0BEEF, 2'b10, 0, 1, 1);
        pool[8] = va(3, 2, 0);
        stall = 1'b1;
        for (int n = 0; n < 60; n++) begin
            logic [31:0] v;
            v = pool[$urandom_range(0, 11)] | 32'($urandom_range(0, 4095));
            lat = $urandom_range(0, 3);
            walk(v, 1'($urandom_range(0, 1)), $urandom_range(0, 2));
        end
        stall = 1'b0;
        repeat (4) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule